// File: doc/BRIEF.md
# Six-Channel Down-Counting Timer Bank

This block holds a set of independent 32-bit countdown timers that software reaches through a plain word-wide register port. Each channel loads a start value into its current-count register. It counts that value down at a tick rate picked from one of four external tick-enable inputs and divided by a programmable power of two. When the count runs out, the channel raises its own pending flag. Depending on its control bits, it then either reloads from its interval register and keeps running, or stops.

A shared enable register masks the pending flags. A single registered interrupt line reports when any enabled channel is pending. Software clears a pending flag by writing a one to its bit in the shared status register. A clear that arrives on the same edge as a fresh expiry loses, so no event is dropped.

The block generates no clock of its own. The surrounding logic supplies single-cycle tick-enable pulses on `tick_src`, and input 1 carries the main oscillator tick.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Interrupt enable is at byte offset 0x00 and status at 0x04, with bit n belonging to channel n. Channel n has control at 0x10+0x10·n, interval at 0x14+0x10·n and current count at 0x18+0x10·n. Any other offset, including unaligned ones, reads zero and ignores writes.
- R3: While control bit 0 (run) is set, each effective tick lowers the current count by one. With run clear, the count holds. A software write to the current-count register sets the count directly.
- R4: An effective tick that finds the current count at 1 (or 0) is an expiry, and it sets status bit n.
- R5: On expiry, if control bit 1 (reload) is set and bit 7 (single-shot) is clear, the count reloads from the interval register and run stays set. An interval of all ones therefore wraps from 1 to 0xFFFFFFFF and continues to 0xFFFFFFFE.
- R6: On expiry, if bit 1 is clear or bit 7 is set, the count becomes 0 and run (bit 0) clears, while the other control bits keep their values.
- R7: Control bits 3:2 select which `tick_src` bit drives the channel; value 01 selects input 1, the oscillator tick. Pulses on the other inputs have no effect.
- R8: Control bits 6:4 hold k. The channel takes an effective tick on every 2^k-th selected source pulse, counted from when run was set.
- R9: Writing 1 to a status bit clears that flag, and writing 0 leaves it set. An expiry on the same edge as a clearing write leaves the flag set.
- R10: `irq` is registered. It is high in the cycle after any channel has both its status bit and its enable bit set, and low otherwise.
- R11: `bus_rdata` takes the addressed register's value on an edge where `bus_ren` is high and holds it at other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| tick_src | input | 4 | Tick-enable pulses, one per clock source |
| irq | output | 1 | Combined interrupt request |

## Verification
Ticks are delivered as single pulses under bench control, so every count can be read back exactly between pulses. A start value of 3 with no reload tells a decrement apart from a stop. A reload with a short interval tells one-shot behaviour from continuous behaviour, and the single-shot bit combined with reload tells which of the two bits wins. Pulses on an unselected source against a selected one tell the source multiplexer apart from a shared tick. A divide-by-four channel read after three and then four pulses pins down exactly where the divider fires. An interval of all ones exercises the wrap. A clearing write on the same edge as an expiry, and a pending channel that is not enabled, separate the set/clear priority and the interrupt masking.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SRC_W  = 2;
  localparam int NSRC   = 1 << SRC_W;
  localparam int DIV_W  = 3;
  localparam int CTRL_W = 8;

  localparam int ADDR_IEN = 'h00;
  localparam int ADDR_STS = 'h04;

  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_INTV = 4'h4;
  localparam logic [3:0] OFF_CUR  = 4'h8;

  typedef struct packed {
    logic             single;
    logic [DIV_W-1:0] div;
    logic [SRC_W-1:0] src;
    logic             reload;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int DW_DIV = DIV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              src_tick,
  input  logic [DW_DIV-1:0] div,
  output logic              tick
);
  localparam int PCW = (1 << DW_DIV) - 1;

  logic [PCW-1:0] pre_cnt;
  logic [PCW-1:0] mask;

  always_comb begin
    mask = PCW'((32'd1 << div) - 32'd1);
    tick = run && src_tick && ((pre_cnt & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pre_cnt <= '0;
    else if (src_tick) pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_ticks,
  input  logic              ctrl_we,
  input  logic              intv_we,
  input  logic              cur_we,
  input  logic [DW-1:0]     wdata,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DW-1:0]     intv_o,
  output logic [DW-1:0]     cur_o,
  output logic              expire,
  output logic              reload_mode
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] intv_q;
  logic [DW-1:0] cur_q;
  logic          tick;

  tmr_prescale #(.DW_DIV(DIV_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .run      (ctrl_q.run),
    .src_tick (src_ticks[ctrl_q.src]),
    .div      (ctrl_q.div),
    .tick     (tick)
  );

  always_comb begin
    expire      = tick && (cur_q <= DW'(1));
    reload_mode = ctrl_q.reload && !ctrl_q.single;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      intv_q <= '0;
      cur_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      else if (expire && !reload_mode) ctrl_q.run <= 1'b0;

      if (intv_we) intv_q <= wdata;

      if (cur_we) cur_q <= wdata;
      else if (expire) cur_q <= reload_mode ? intv_q : '0;
      else if (tick) cur_q <= cur_q - 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;
  assign intv_o = intv_q;
  assign cur_o  = cur_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wen,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_ren,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] tick_src,
  output logic            irq
);
  localparam int PG_W = AW - 4;

  logic [PG_W-1:0] page;
  logic [3:0]      off;
  logic            sel_ien, sel_sts;

  logic [NCH-1:0]             ch_sel;
  logic [NCH-1:0]             ctrl_we, intv_we, cur_we;
  logic [NCH-1:0]             expire_v, reload_v;
  logic [NCH-1:0][CTRL_W-1:0] ctrl_all;
  logic [NCH-1:0][DW-1:0]     intv_all;
  logic [NCH-1:0][DW-1:0]     cur_all;

  logic [NCH-1:0] en_q, pend_q, clr_v;
  logic [DW-1:0]  rd_mux;

  assign page    = bus_addr[AW-1:4];
  assign off     = bus_addr[3:0];
  assign sel_ien = (bus_addr == AW'(ADDR_IEN));
  assign sel_sts = (bus_addr == AW'(ADDR_STS));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_sel[i]  = (page == PG_W'(i + 1));
    assign ctrl_we[i] = bus_wen && ch_sel[i] && (off == OFF_CTRL);
    assign intv_we[i] = bus_wen && ch_sel[i] && (off == OFF_INTV);
    assign cur_we[i]  = bus_wen && ch_sel[i] && (off == OFF_CUR);

    tmr_channel #(.DW(DW)) u_ch (
      .clk         (clk),
      .rst         (rst),
      .src_ticks   (tick_src),
      .ctrl_we     (ctrl_we[i]),
      .intv_we     (intv_we[i]),
      .cur_we      (cur_we[i]),
      .wdata       (bus_wdata),
      .ctrl_o      (ctrl_all[i]),
      .intv_o      (intv_all[i]),
      .cur_o       (cur_all[i]),
      .expire      (expire_v[i]),
      .reload_mode (reload_v[i])
    );
  end

  assign clr_v = (bus_wen && sel_sts) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (bus_wen && sel_ien) en_q <= bus_wdata[NCH-1:0];
      pend_q <= (pend_q & ~clr_v) | expire_v;
      irq    <= |(pend_q & en_q);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_ien) rd_mux = DW'(en_q);
    else if (sel_sts) rd_mux = DW'(pend_q);
    for (int i = 0; i < NCH; i++) begin
      if (ch_sel[i]) begin
        case (off)
          OFF_CTRL: rd_mux = DW'(ctrl_all[i]);
          OFF_INTV: rd_mux = intv_all[i];
          OFF_CUR:  rd_mux = cur_all[i];
          default:  rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_ren) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic [AW-1:0]              bus_addr,
  input logic                       bus_wen,
  input logic [DW-1:0]              bus_wdata,
  input logic [NCH-1:0]             pend_q,
  input logic [NCH-1:0]             expire_v,
  input logic [NCH-1:0]             reload_v,
  input logic [NCH-1:0]             ctrl_we,
  input logic [NCH-1:0]             intv_we,
  input logic [NCH-1:0]             cur_we,
  input logic [NCH-1:0][CTRL_W-1:0] ctrl_all,
  input logic [NCH-1:0][DW-1:0]     intv_all,
  input logic [NCH-1:0][DW-1:0]     cur_all
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_pend_set_r4: assert property (@(posedge clk) disable iff (rst)
      expire_v[i] |=> pend_q[i]);

    p_w1c_only_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(pend_q[i]) |-> $past(bus_wen && (bus_addr == AW'(ADDR_STS)) && bus_wdata[i]));

    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (rst)
      (expire_v[i] && !reload_v[i] && !ctrl_we[i]) |=> !ctrl_all[i][0]);

    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
      (expire_v[i] && reload_v[i] && !cur_we[i] && !intv_we[i])
        |=> (cur_all[i] == $past(intv_all[i])));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
      (!cur_we[i] && !expire_v[i])
        |=> (cur_all[i] == $past(cur_all[i]) || cur_all[i] == $past(cur_all[i]) - 1'b1));
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wen   (bus_wen),
  .bus_wdata (bus_wdata),
  .pend_q    (pend_q),
  .expire_v  (expire_v),
  .reload_v  (reload_v),
  .ctrl_we   (ctrl_we),
  .intv_we   (intv_we),
  .cur_we    (cur_we),
  .ctrl_all  (ctrl_all),
  .intv_all  (intv_all),
  .cur_all   (cur_all)
);

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] OSC = 4'b0010;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ren = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_src = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_bank dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .tick_src(tick_src), .irq(irq)
  );

  function automatic logic [7:0] a_ctrl(int n); return 8'(8'h10 + 8'h10 * n); endfunction
  function automatic logic [7:0] a_intv(int n); return 8'(8'h14 + 8'h10 * n); endfunction
  function automatic logic [7:0] a_cur(int n);  return 8'(8'h18 + 8'h10 * n); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_ren = 1'b1;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rdchk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pulse(logic [3:0] m, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_src = m;
      @(negedge clk); tick_src = '0;
    end
  endtask

  task automatic irqchk(string req, logic exp);
    @(negedge clk); @(negedge clk);
    chk(req, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rdchk("R1 ien", 8'h00, 0);
    rdchk("R1 sts", 8'h04, 0);
    rdchk("R1 ctrl0", a_ctrl(0), 0);
    rdchk("R1 intv0", a_intv(0), 0);
    rdchk("R1 cur5", a_cur(5), 0);
  endtask

  task automatic t_oneshot;
    wr(8'h00, 32'h1);
    wr(a_cur(0), 3);
    wr(a_ctrl(0), 32'h05);
    pulse(OSC, 2);
    rdchk("R3 decrement", a_cur(0), 1);
    rdchk("R4 no early pending", 8'h04, 0);
    pulse(OSC, 1);
    rdchk("R4 pending", 8'h04, 1);
    rdchk("R6 count zero", a_cur(0), 0);
    rdchk("R6 run cleared", a_ctrl(0), 32'h04);
    irqchk("R10 irq on enabled pending", 1'b1);
    pulse(OSC, 2);
    rdchk("R3 stopped holds", a_cur(0), 0);
  endtask

  task automatic t_w1c;
    wr(8'h04, 0);
    rdchk("R9 write0 keeps", 8'h04, 1);
    wr(8'h04, 1);
    rdchk("R9 write1 clears", 8'h04, 0);
    irqchk("R10 irq drops", 1'b0);
  endtask

  task automatic t_reload;
    wr(a_intv(2), 4);
    wr(a_cur(2), 2);
    wr(a_ctrl(2), 32'h07);
    pulse(OSC, 2);
    rdchk("R5 pending", 8'h04, 32'h04);
    rdchk("R5 reloaded", a_cur(2), 4);
    rdchk("R5 still running", a_ctrl(2), 32'h07);
    wr(8'h04, 32'h04);
    pulse(OSC, 3);
    rdchk("R5 second period count", a_cur(2), 1);
    rdchk("R5 second period not yet", 8'h04, 0);
    pulse(OSC, 1);
    rdchk("R5 second expiry", 8'h04, 32'h04);
    wr(a_ctrl(2), 0);
    wr(8'h04, 32'h3f);
  endtask

  task automatic t_single;
    wr(a_intv(3), 9);
    wr(a_cur(3), 2);
    wr(a_ctrl(3), 32'h87);
    pulse(OSC, 2);
    rdchk("R6 single pending", 8'h04, 32'h08);
    rdchk("R6 single count", a_cur(3), 0);
    rdchk("R6 single run off", a_ctrl(3), 32'h86);
    rdchk("R2 interval readback", a_intv(3), 9);
    wr(8'h04, 32'h08);
  endtask

  task automatic t_prescale;
    wr(a_cur(1), 2);
    wr(a_ctrl(1), 32'h25);
    pulse(OSC, 3);
    rdchk("R8 div4 after 3", a_cur(1), 2);
    pulse(OSC, 1);
    rdchk("R8 div4 after 4", a_cur(1), 1);
    pulse(OSC, 3);
    rdchk("R8 div4 after 7", 8'h04, 0);
    pulse(OSC, 1);
    rdchk("R8 div4 after 8", 8'h04, 32'h02);
    wr(8'h04, 32'h02);
  endtask

  task automatic t_source;
    wr(a_cur(4), 3);
    wr(a_ctrl(4), 32'h09);
    pulse(OSC, 3);
    rdchk("R7 other source ignored", a_cur(4), 3);
    pulse(4'b0100, 1);
    rdchk("R7 selected source", a_cur(4), 2);
    wr(a_ctrl(4), 0);
  endtask

  task automatic t_mask;
    wr(a_cur(5), 1);
    wr(a_ctrl(5), 32'h05);
    pulse(OSC, 1);
    rdchk("R10 ch5 pending", 8'h04, 32'h20);
    irqchk("R10 masked", 1'b0);
    wr(8'h00, 32'h21);
    irqchk("R10 unmasked", 1'b1);
    wr(8'h04, 32'h20);
    wr(8'h00, 32'h01);
  endtask

  task automatic t_collide;
    wr(a_cur(0), 1);
    wr(a_ctrl(0), 32'h05);
    @(negedge clk);
    bus_addr = 8'h04; bus_wdata = 1; bus_wen = 1'b1; tick_src = OSC;
    @(negedge clk);
    bus_wen = 1'b0; tick_src = '0;
    rdchk("R9 expiry beats clear", 8'h04, 1);
    wr(8'h04, 1);
  endtask

  task automatic t_wrap;
    wr(a_intv(0), 32'hFFFF_FFFF);
    wr(a_cur(0), 1);
    wr(a_ctrl(0), 32'h07);
    pulse(OSC, 1);
    rdchk("R5 wrap to ones", a_cur(0), 32'hFFFF_FFFF);
    pulse(OSC, 1);
    rdchk("R5 wrap continues", a_cur(0), 32'hFFFF_FFFE);
    wr(a_ctrl(0), 0);
    wr(8'h04, 32'h3f);
  endtask

  task automatic t_halt;
    wr(a_cur(0), 7);
    wr(a_ctrl(0), 32'h05);
    pulse(OSC, 1);
    rdchk("R3 running", a_cur(0), 6);
    wr(a_ctrl(0), 32'h04);
    pulse(OSC, 3);
    rdchk("R3 halted holds", a_cur(0), 6);
  endtask

  task automatic t_unmapped;
    wr(8'h0C, 32'hDEAD_BEEF);
    rdchk("R2 unmapped 0x0C", 8'h0C, 0);
    rdchk("R2 unmapped 0x1C", 8'h1C, 0);
    rdchk("R2 unaligned 0x11", 8'h11, 0);
    rdchk("R2 past last channel", 8'h78, 0);
    rdchk("R11 read intv", a_intv(3), 9);
    @(negedge clk); bus_addr = a_cur(0);
    @(negedge clk); @(negedge clk);
    chk("R11 data holds without read", bus_rdata, 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_oneshot();
    t_w1c();
    t_reload();
    t_single();
    t_prescale();
    t_source();
    t_mask();
    t_collide();
    t_wrap();
    t_halt();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule